// File: doc/BRIEF.md
# Core Module Control Register Block

This block is the system-control register file of a processor core module. A host reaches it through a single-cycle word-addressed port: the word index is the byte offset divided by four. A write is taken on the clock edge while `bus_wr` is high. Read data is combinational from the index presented.

The file returns fixed identification and status words. It holds two oscillator settings, and these accept writes only after a 16-bit unlock key has been written to the lock register. A control word drives an LED, selects memory remap and can ask for a system reset. There are two set/clear flag words, SDRAM and init words that only store values, and a free-running reference counter. A read-only window shows a small memory-description byte table. A software-interrupt section has separate IRQ and FIQ enables, and each drives its own interrupt line.

Real oscillator, voltage and SDRAM timing effects are not modelled. Those registers either store values or read as zero.

Top module: `coremod_ctrl`

## Requirements
- R1: Index 0 reads 0x411A3001 and index 4 reads 0x00100000. Index 1, indices 32 to 35 and every unassigned index below 64 read 0.
- R2: After reset, index 2 reads 0x01000048 and index 7 reads 0x0007FEFF. Index 9 reads 0x00000112. Index 8 reads 0x00011122 ORed with a size code set by `MEM_MB`: 0x10 for 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, else 0. The default of 128 gives 0x0001112E. All outputs reset low.
- R3: A write to index 5 keeps only bits 15:0. A read returns those bits, and bit 16 is set exactly when they equal the key 0xA05F.
- R4: Writes to index 2 and index 7 take effect only while the stored lock value equals 0xA05F. Otherwise they are dropped.
- R5: Index 3 stores write bits 0 and 2 only, and reads bit 3 as 0. `led_o` follows bit 0. `remap_o` follows bit 2, and high means the boot flash alias at address 0 is off.
- R6: A write to index 3 with bit 3 set raises `rst_req_o` for exactly the one cycle after the write edge.
- R7: Index 12 reads the flags. A write to 12 ORs the data in, and a write to 13 clears the bits written as 1. Index 14 (set) and index 15 (clear) work the same way on the second flag word.
- R8: Index 10 reads a 32-bit counter that resets to 0 and rises by one every `REF_DIV` clocks (default one per clock). Writes to it are ignored.
- R9: Indices 64 to 95 read table entry <index> in bits 7:0. Entry 64 holds the density byte (32 at the default size), entries 73 to 82 hold ASCII "CORE-SDRAM", and every other entry is 0. Indices 96 to 127 read 0.
- R10: A write to index 20 with bit 0 set raises the software level, and a write to 21 with bit 0 set clears it. Writes with bit 0 clear do nothing. Indices 17, 25 and 20 read the level in bit 0. Index 18/19 sets/clears the IRQ enables and index 26/27 the FIQ enables, and 18 and 26 read them back. Index 16 (IRQ) and index 24 (FIQ) read the level ANDed with the enable. `irq_o` and `fiq_o` are high when those status words are non-zero.
- R11: Indices 8 and 9 store all 32 written bits.
- R12: Writes to read-only or unassigned indices change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_idx | input | 7 | Word index (byte offset >> 2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_idx` |
| led_o | output | 1 | LED drive, control bit 0 |
| remap_o | output | 1 | Remap select, control bit 2 |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | IRQ line |
| fiq_o | output | 1 | FIQ line |

## Verification
The hardest case to reach is an oscillator write that lands while the key is not held. This includes a write just after the key has been replaced by another value. The stimulus writes the key, changes both oscillators, overwrites the lock with a different value, and then tries again. It expects the lock readback to lose bit 16 and the oscillators to keep their unlocked values. The reset pulse is sampled in the cycle right after the write edge and again one cycle later, to prove it lasts exactly one cycle.

// File: rtl/coremod_ctrl_pkg.sv
package coremod_ctrl_pkg;

    localparam int IDX_W  = 7;
    localparam int DATA_W = 32;

    localparam logic [IDX_W-1:0] IX_ID      = 7'd0;
    localparam logic [IDX_W-1:0] IX_OSC     = 7'd2;
    localparam logic [IDX_W-1:0] IX_CTRL    = 7'd3;
    localparam logic [IDX_W-1:0] IX_STAT    = 7'd4;
    localparam logic [IDX_W-1:0] IX_LOCK    = 7'd5;
    localparam logic [IDX_W-1:0] IX_AUX     = 7'd7;
    localparam logic [IDX_W-1:0] IX_SDRAM   = 7'd8;
    localparam logic [IDX_W-1:0] IX_INIT    = 7'd9;
    localparam logic [IDX_W-1:0] IX_REF     = 7'd10;
    localparam logic [IDX_W-1:0] IX_FLG     = 7'd12;
    localparam logic [IDX_W-1:0] IX_FLGCLR  = 7'd13;
    localparam logic [IDX_W-1:0] IX_NVF     = 7'd14;
    localparam logic [IDX_W-1:0] IX_NVFCLR  = 7'd15;
    localparam logic [IDX_W-1:0] IX_IRQ_ST  = 7'd16;
    localparam logic [IDX_W-1:0] IX_IRQ_RAW = 7'd17;
    localparam logic [IDX_W-1:0] IX_IRQ_ENS = 7'd18;
    localparam logic [IDX_W-1:0] IX_IRQ_ENC = 7'd19;
    localparam logic [IDX_W-1:0] IX_SWI_SET = 7'd20;
    localparam logic [IDX_W-1:0] IX_SWI_CLR = 7'd21;
    localparam logic [IDX_W-1:0] IX_FIQ_ST  = 7'd24;
    localparam logic [IDX_W-1:0] IX_FIQ_RAW = 7'd25;
    localparam logic [IDX_W-1:0] IX_FIQ_ENS = 7'd26;
    localparam logic [IDX_W-1:0] IX_FIQ_ENC = 7'd27;

    localparam logic [DATA_W-1:0] ID_WORD   = 32'h411A3001;
    localparam logic [DATA_W-1:0] STAT_WORD = 32'h00100000;

    typedef struct packed {
        logic [DATA_W-1:0] osc;
        logic [DATA_W-1:0] aux;
        logic              led;
        logic              remap;
        logic              rst_req;
        logic [15:0]       lock;
        logic [DATA_W-1:0] sdram;
        logic [DATA_W-1:0] init;
        logic [DATA_W-1:0] flags;
        logic [DATA_W-1:0] nvflags;
    } cm_regs_t;

    typedef struct packed {
        logic              swi;
        logic [DATA_W-1:0] irq_en;
        logic [DATA_W-1:0] fiq_en;
    } cm_int_t;

    function automatic logic [DATA_W-1:0] size_code(int unsigned mb);
        if (mb >= 256)      return 32'h10;
        else if (mb >= 128) return 32'h0C;
        else if (mb >= 64)  return 32'h08;
        else if (mb >= 32)  return 32'h04;
        else                return 32'h00;
    endfunction

    function automatic logic [7:0] density(int unsigned mb);
        if (mb >= 256)      return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else                return 8'd2;
    endfunction

    function automatic logic [7:0] spd_byte(int unsigned ent, int unsigned mb);
        logic [79:0] tag;
        tag = "CORE-SDRAM";
        if (ent == 64)
            return density(mb);
        else if (ent >= 73 && ent <= 82)
            return tag[79 - 8*(ent-73) -: 8];
        else
            return 8'h00;
    endfunction

endpackage

// File: rtl/coremod_refcnt.sv
module coremod_refcnt #(
    parameter int REF_DIV = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] count
);
    localparam int PW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

    logic        tick;
    logic [31:0] cnt_d, cnt_q;

    generate
        if (REF_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] pre_d, pre_q;
            always_comb begin
                tick  = (pre_q == PW'(REF_DIV-1));
                pre_d = tick ? '0 : pre_q + 1'b1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end
        end
    endgenerate

    always_comb begin
        cnt_d = tick ? cnt_q + 32'd1 : cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R8: a tick advances the count by exactly one
    assert_ref_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == $past(cnt_q) + 32'd1));

endmodule

// File: rtl/coremod_spd.sv
module coremod_spd #(
    parameter int MEM_MB = 128
) (
    input  logic [coremod_ctrl_pkg::IDX_W-1:0] idx,
    output logic [7:0]                         data
);
    localparam int WIN = 32;
    localparam int BASE = 64;

    logic [7:0] rom [WIN];

    generate
        for (genvar g = 0; g < WIN; g++) begin : g_rom
            assign rom[g] = coremod_ctrl_pkg::spd_byte(BASE + g, MEM_MB);
        end
    endgenerate

    assign data = (idx[6] && !idx[5]) ? rom[idx[4:0]] : 8'h00;

endmodule

// File: rtl/coremod_intc.sv
module coremod_intc
    import coremod_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              level,
    output logic [DATA_W-1:0] irq_en,
    output logic [DATA_W-1:0] fiq_en,
    output logic              irq_o,
    output logic              fiq_o
);
    cm_int_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (idx)
                IX_IRQ_ENS: st_d.irq_en = st_q.irq_en | wdata;
                IX_IRQ_ENC: st_d.irq_en = st_q.irq_en & ~wdata;
                IX_FIQ_ENS: st_d.fiq_en = st_q.fiq_en | wdata;
                IX_FIQ_ENC: st_d.fiq_en = st_q.fiq_en & ~wdata;
                IX_SWI_SET: if (wdata[0]) st_d.swi = 1'b1;
                IX_SWI_CLR: if (wdata[0]) st_d.swi = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level  = st_q.swi;
    assign irq_en = st_q.irq_en;
    assign fiq_en = st_q.fiq_en;
    assign irq_o  = st_q.swi & st_q.irq_en[0];
    assign fiq_o  = st_q.swi & st_q.fiq_en[0];

    // R10: a set write with bit 0 raises the level
    assert_swi_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IX_SWI_SET && wdata[0]) |=> st_q.swi);

    // R10: no interrupt line without a raw level
    assert_line_needs_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> level);

endmodule

// File: rtl/coremod_ctrl.sv
module coremod_ctrl
    import coremod_ctrl_pkg::*;
#(
    parameter int          MEM_MB     = 128,
    parameter int          REF_DIV    = 1,
    parameter logic [15:0] UNLOCK_KEY = 16'hA05F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              led_o,
    output logic              remap_o,
    output logic              rst_req_o,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam cm_regs_t RST_VAL = '{
        osc:     32'h01000048,
        aux:     32'h0007FEFF,
        led:     1'b0,
        remap:   1'b0,
        rst_req: 1'b0,
        lock:    16'h0000,
        sdram:   32'h00011122 | size_code(MEM_MB),
        init:    32'h00000112,
        flags:   32'h0,
        nvflags: 32'h0
    };

    cm_regs_t          st_d, st_q;
    logic              key_ok;
    logic [DATA_W-1:0] refcnt;
    logic [7:0]        spd_data;
    logic              swi_level;
    logic [DATA_W-1:0] irq_en, fiq_en;

    coremod_refcnt #(.REF_DIV(REF_DIV)) u_refcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .count (refcnt)
    );

    coremod_spd #(.MEM_MB(MEM_MB)) u_spd (
        .idx  (bus_idx),
        .data (spd_data)
    );

    coremod_intc u_intc (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .idx    (bus_idx),
        .wdata  (bus_wdata),
        .level  (swi_level),
        .irq_en (irq_en),
        .fiq_en (fiq_en),
        .irq_o  (irq_o),
        .fiq_o  (fiq_o)
    );

    assign key_ok = (st_q.lock == UNLOCK_KEY);

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        if (bus_wr) begin
            case (bus_idx)
                IX_OSC:    if (key_ok) st_d.osc = bus_wdata;
                IX_AUX:    if (key_ok) st_d.aux = bus_wdata;
                IX_CTRL: begin
                    st_d.led     = bus_wdata[0];
                    st_d.remap   = bus_wdata[2];
                    st_d.rst_req = bus_wdata[3];
                end
                IX_LOCK:   st_d.lock    = bus_wdata[15:0];
                IX_SDRAM:  st_d.sdram   = bus_wdata;
                IX_INIT:   st_d.init    = bus_wdata;
                IX_FLG:    st_d.flags   = st_q.flags | bus_wdata;
                IX_FLGCLR: st_d.flags   = st_q.flags & ~bus_wdata;
                IX_NVF:    st_d.nvflags = st_q.nvflags | bus_wdata;
                IX_NVFCLR: st_d.nvflags = st_q.nvflags & ~bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_idx[6]) begin
            bus_rdata = {24'h0, spd_data};
        end else begin
            case (bus_idx)
                IX_ID:      bus_rdata = ID_WORD;
                IX_STAT:    bus_rdata = STAT_WORD;
                IX_OSC:     bus_rdata = st_q.osc;
                IX_AUX:     bus_rdata = st_q.aux;
                IX_CTRL:    bus_rdata = {29'h0, st_q.remap, 1'b0, st_q.led};
                IX_LOCK:    bus_rdata = {15'h0, key_ok, st_q.lock};
                IX_SDRAM:   bus_rdata = st_q.sdram;
                IX_INIT:    bus_rdata = st_q.init;
                IX_REF:     bus_rdata = refcnt;
                IX_FLG:     bus_rdata = st_q.flags;
                IX_NVF:     bus_rdata = st_q.nvflags;
                IX_IRQ_ST:  bus_rdata = {31'h0, swi_level & irq_en[0]};
                IX_FIQ_ST:  bus_rdata = {31'h0, swi_level & fiq_en[0]};
                IX_IRQ_RAW,
                IX_FIQ_RAW,
                IX_SWI_SET: bus_rdata = {31'h0, swi_level};
                IX_IRQ_ENS: bus_rdata = irq_en;
                IX_FIQ_ENS: bus_rdata = fiq_en;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign led_o     = st_q.led;
    assign remap_o   = st_q.remap;
    assign rst_req_o = st_q.rst_req;

    // R6: the reset request never lasts two cycles
    assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    // R4: without the key both oscillator words hold
    assert_osc_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !key_ok |=> ($stable(st_q.osc) && $stable(st_q.aux)));

    // R5: control readback never shows the reset bit or bit 1
    assert_ctrl_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idx == IX_CTRL) |-> (bus_rdata[3] == 1'b0 && bus_rdata[1] == 1'b0));

    // R7: a clear write leaves none of the written bits set
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_idx == IX_FLGCLR) |=> ((st_q.flags & $past(bus_wdata)) == '0));

    // R9: the upper table window is empty
    assert_spd_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idx[6:5] == 2'b11) |-> (bus_rdata == '0));

endmodule

// File: tb/coremod_ctrl_test.sv
module coremod_ctrl_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [6:0]  idx;
        logic [31:0] val;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 7'd0,   32'h411A3001, 4'd1},  // R1 id
        '{1'b0, 7'd4,   32'h00100000, 4'd1},  // R1 status
        '{1'b0, 7'd2,   32'h01000048, 4'd2},  // R2
        '{1'b0, 7'd7,   32'h0007FEFF, 4'd2},  // R2
        '{1'b0, 7'd8,   32'h0001112E, 4'd2},  // R2
        '{1'b0, 7'd9,   32'h00000112, 4'd2},  // R2
        '{1'b1, 7'd2,   32'h12345678, 4'd4},  // R4 locked write
        '{1'b0, 7'd2,   32'h01000048, 4'd4},
        '{1'b1, 7'd5,   32'hFFFFA05F, 4'd3},  // R3 key
        '{1'b0, 7'd5,   32'h0001A05F, 4'd3},
        '{1'b1, 7'd2,   32'h12345678, 4'd4},
        '{1'b0, 7'd2,   32'h12345678, 4'd4},
        '{1'b1, 7'd7,   32'h00ABCDEF, 4'd4},
        '{1'b0, 7'd7,   32'h00ABCDEF, 4'd4},
        '{1'b1, 7'd5,   32'h00001234, 4'd3},  // R3 other value
        '{1'b0, 7'd5,   32'h00001234, 4'd3},
        '{1'b1, 7'd7,   32'h00000000, 4'd4},  // R4 relocked
        '{1'b0, 7'd7,   32'h00ABCDEF, 4'd4},
        '{1'b1, 7'd3,   32'h0000000F, 4'd5},  // R5
        '{1'b0, 7'd3,   32'h00000005, 4'd5},
        '{1'b1, 7'd12,  32'h000000F0, 4'd7},  // R7
        '{1'b1, 7'd12,  32'h0000000F, 4'd7},
        '{1'b0, 7'd12,  32'h000000FF, 4'd7},
        '{1'b1, 7'd13,  32'h0000003C, 4'd7},
        '{1'b0, 7'd12,  32'h000000C3, 4'd7},
        '{1'b1, 7'd14,  32'h80000001, 4'd7},
        '{1'b1, 7'd15,  32'h00000001, 4'd7},
        '{1'b0, 7'd14,  32'h80000000, 4'd7},
        '{1'b1, 7'd8,   32'hDEADBEEF, 4'd11}, // R11
        '{1'b0, 7'd8,   32'hDEADBEEF, 4'd11},
        '{1'b1, 7'd9,   32'h0000CAFE, 4'd11},
        '{1'b0, 7'd9,   32'h0000CAFE, 4'd11},
        '{1'b0, 7'd64,  32'h00000020, 4'd9},  // R9
        '{1'b0, 7'd73,  32'h00000043, 4'd9},
        '{1'b0, 7'd82,  32'h0000004D, 4'd9},
        '{1'b0, 7'd100, 32'h00000000, 4'd9},
        '{1'b0, 7'd65,  32'h00000000, 4'd9},
        '{1'b1, 7'd0,   32'hFFFFFFFF, 4'd12}, // R12
        '{1'b0, 7'd0,   32'h411A3001, 4'd12},
        '{1'b1, 7'd33,  32'h00000005, 4'd1},  // R1 voltage index
        '{1'b0, 7'd33,  32'h00000000, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_idx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        led_o, remap_o, rst_req_o, irq_o, fiq_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] a, b, c;

    always #(CLK_PERIOD/2) clk = ~clk;

    coremod_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_idx   (bus_idx),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .led_o     (led_o),
        .remap_o   (remap_o),
        .rst_req_o (rst_req_o),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] i, input logic [31:0] d);
        @(negedge clk);
        bus_idx = i; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] i, output logic [31:0] d);
        bus_idx = i;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (CLK_PERIOD * 5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: outputs low after reset
        chk("R2 led", {31'h0, led_o}, 32'h0);
        chk("R2 remap", {31'h0, remap_o}, 32'h0);
        chk("R2 rstreq", {31'h0, rst_req_o}, 32'h0);
        chk("R2 irq", {31'h0, irq_o}, 32'h0);
        chk("R2 fiq", {31'h0, fiq_o}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VECS[k].wr) begin
                wr(VECS[k].idx, VECS[k].val);
            end else begin
                rd(VECS[k].idx, a);
                chk($sformatf("R%0d vec %0d", VECS[k].req, k), a, VECS[k].val);
            end
        end

        // R5: outputs follow control bits
        chk("R5 led", {31'h0, led_o}, 32'h1);
        chk("R5 remap", {31'h0, remap_o}, 32'h1);
        wr(7'd3, 32'h1);
        chk("R5 led only", {30'h0, remap_o, led_o}, 32'h1);
        wr(7'd3, 32'h4);
        chk("R5 remap only", {30'h0, remap_o, led_o}, 32'h2);

        // R6: one-cycle pulse after the write edge
        wr(7'd3, 32'h8);
        chk("R6 pulse high", {31'h0, rst_req_o}, 32'h1);
        @(negedge clk);
        chk("R6 pulse gone", {31'h0, rst_req_o}, 32'h0);
        chk("R5 cleared", {30'h0, remap_o, led_o}, 32'h0);

        // R8: counter steps once per clock and ignores writes
        rd(7'd10, a);
        repeat (7) @(negedge clk);
        rd(7'd10, b);
        chk("R8 step", b - a, 32'd7);
        wr(7'd10, 32'h0);
        rd(7'd10, c);
        chk("R8 write ignored", c - b, 32'd2);

        // R10: interrupt section
        wr(7'd18, 32'h1);
        chk("R10 irq no level", {31'h0, irq_o}, 32'h0);
        wr(7'd20, 32'h1);
        chk("R10 irq on", {31'h0, irq_o}, 32'h1);
        chk("R10 fiq off", {31'h0, fiq_o}, 32'h0);
        rd(7'd16, a); chk("R10 irq status", a, 32'h1);
        rd(7'd17, a); chk("R10 raw", a, 32'h1);
        rd(7'd20, a); chk("R10 swi read", a, 32'h1);
        rd(7'd24, a); chk("R10 fiq status", a, 32'h0);
        wr(7'd26, 32'h0000FFFF);
        chk("R10 fiq on", {31'h0, fiq_o}, 32'h1);
        rd(7'd26, a); chk("R10 fiq enables", a, 32'h0000FFFF);
        wr(7'd19, 32'h1);
        chk("R10 irq cleared en", {31'h0, irq_o}, 32'h0);
        rd(7'd18, a); chk("R10 irq enables", a, 32'h0);
        wr(7'd21, 32'h1);
        chk("R10 fiq no level", {31'h0, fiq_o}, 32'h0);
        rd(7'd25, a); chk("R10 raw clear", a, 32'h0);
        wr(7'd20, 32'h2);
        rd(7'd17, a); chk("R10 bit0 clear ignored", a, 32'h0);

        // R12: write to a status index changes nothing
        wr(7'd4, 32'h0);
        rd(7'd4, a); chk("R12 status kept", a, 32'h00100000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule